// File: doc/BRIEF.md
# Single-Issue Function Unit Dispatcher

This block sits between an instruction issuer and a set of function units. It takes one decoded instruction at a time, made of a kind code, a unit-class field, an operand bundle and a register read mask. It sends the instruction to the single unit whose fixed class mask overlaps the class field. That unit gets an issue strobe, the operands and the inverted read mask. The block does no hazard analysis. It reports busy while any unit works, and drives its input ready as the inverse of that busy. The issuer therefore waits for each instruction to finish before it offers the next one.

Two kinds of instruction never reach a unit. A halt raises a terminate flag that stays set until reset. A no-op produces a short busy window from a small down-counter, so the issuer still sees busy rise and then fall. The exception flags of all units are ORed into one output.

Top module: `fu_dispatch`

## Requirements
- R1: With `in_valid` high and an ordinary kind (code 0 or 3), `fu_issue[u]` is high exactly when `in_class & MASK[u]` is nonzero. `MASK[u]` is bits `u*CLASS_W +: CLASS_W` of `UNIT_MASKS`, and by default `MASK[u] = 1 << u`. At most one unit may match.
- R2: The operand lane `fu_oper[u*OPER_W +: OPER_W]` carries `in_oper` while unit u is issued, and is zero otherwise.
- R3: While `in_valid` is low, no `fu_issue` bit is high, whatever the class and kind inputs are.
- R4: A halt (kind code 1) with `in_valid` high issues to no unit and sets `terminate` at the next clock edge.
- R5: `terminate` stays high until a synchronous reset (`rst_n` low) clears it.
- R6: A no-op (kind code 2) with `in_valid` high issues to no unit. It raises `core_busy` in the same cycle, and `core_busy` stays high for the next `NOP_HOLD` (default 2) cycles, then falls if no unit is busy.
- R7: `core_busy` is high whenever any `fu_busy` bit is high, and `in_ready` is always the inverse of `core_busy`.
- R8: The lane `fu_rdmask_n[u*RMASK_W +: RMASK_W]` equals `~in_rdmask` while unit u is issued or `fu_busy[u]` is high, and is zero otherwise.
- R9: `exc_any` is the OR of all `fu_exc` bits.
- R10: After reset, with no unit busy and `in_valid` low: `terminate` is 0, `core_busy` is 0, `in_ready` is 1 and no unit is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can accept an instruction (inverse of busy) |
| in_kind | input | 2 | Kind code: 0/3 ordinary, 1 halt, 2 no-op |
| in_class | input | CLASS_W | Unit-class field of the instruction |
| in_oper | input | OPER_W | Operand bundle |
| in_rdmask | input | RMASK_W | Register read mask |
| fu_issue | output | NUM_UNITS | Issue strobe, one bit per unit |
| fu_oper | output | NUM_UNITS*OPER_W | Operand lanes, one per unit |
| fu_rdmask_n | output | NUM_UNITS*RMASK_W | Inverted read-mask lanes, one per unit |
| fu_busy | input | NUM_UNITS | Busy flag from each unit |
| fu_exc | input | NUM_UNITS | Exception flag from each unit |
| core_busy | output | 1 | Any unit busy or no-op window active |
| terminate | output | 1 | Sticky halt flag |
| exc_any | output | 1 | OR of unit exception flags |

## Verification
The case that is hardest to reach from the ports is the tail of the no-op window. There, busy has no external cause: no unit is busy and `in_valid` is already low. The bench offers a single no-op and then drops valid while holding every unit idle. It samples `core_busy` on each of the following cycles to find the exact cycle where busy falls. A second hard case is read-mask holding for a busy unit that is not being issued. The bench raises one unit's busy flag with valid low and checks that only that unit's lane shows the inverted mask.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef enum logic [1:0] {
    KIND_EXEC     = 2'd0,
    KIND_HALT     = 2'd1,
    KIND_NOP      = 2'd2,
    KIND_EXEC_ALT = 2'd3
  } op_kind_e;

  function automatic logic kind_is_exec(input logic [1:0] k);
    return (k == KIND_EXEC) || (k == KIND_EXEC_ALT);
  endfunction

  function automatic logic kind_is_halt(input logic [1:0] k);
    return k == KIND_HALT;
  endfunction

  function automatic logic kind_is_nop(input logic [1:0] k);
    return k == KIND_NOP;
  endfunction

endpackage

// File: rtl/unit_match.sv
module unit_match #(
  parameter int NUM_UNITS = 4,
  parameter int CLASS_W = 4,
  parameter logic [NUM_UNITS*CLASS_W-1:0] UNIT_MASKS = 16'h8421
) (
  input  logic [CLASS_W-1:0]   cls,
  output logic [NUM_UNITS-1:0] hit
);
  function automatic logic overlap(input logic [CLASS_W-1:0] a,
                                   input logic [CLASS_W-1:0] b);
    return |(a & b);
  endfunction

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam logic [CLASS_W-1:0] MY_MASK = UNIT_MASKS[u*CLASS_W +: CLASS_W];
    assign hit[u] = overlap(cls, MY_MASK);
  end
endmodule

// File: rtl/nop_hold.sv
module nop_hold #(
  parameter int NOP_HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);
  localparam int CNT_W = $clog2(NOP_HOLD + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CNT_W'(NOP_HOLD);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign active = (cnt != '0);

  AST_NOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == CNT_W'(NOP_HOLD))); // R6
endmodule

// File: rtl/lane_drive.sv
module lane_drive #(
  parameter int OPER_W = 16,
  parameter int RMASK_W = 4
) (
  input  logic               sel,
  input  logic               unit_busy,
  input  logic [OPER_W-1:0]  oper_in,
  input  logic [RMASK_W-1:0] rdmask_in,
  output logic               issue,
  output logic [OPER_W-1:0]  oper_out,
  output logic [RMASK_W-1:0] rdmask_n_out
);
  logic hold_mask;

  assign hold_mask    = sel | unit_busy;
  assign issue        = sel;
  assign oper_out     = sel ? oper_in : '0;
  assign rdmask_n_out = hold_mask ? ~rdmask_in : '0;
endmodule

// File: rtl/fu_dispatch.sv
module fu_dispatch
  import disp_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int CLASS_W = 4,
  parameter int OPER_W = 16,
  parameter int RMASK_W = 4,
  parameter logic [NUM_UNITS*CLASS_W-1:0] UNIT_MASKS = 16'h8421,
  parameter int NOP_HOLD = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [1:0]                    in_kind,
  input  logic [CLASS_W-1:0]            in_class,
  input  logic [OPER_W-1:0]             in_oper,
  input  logic [RMASK_W-1:0]            in_rdmask,
  output logic [NUM_UNITS-1:0]          fu_issue,
  output logic [NUM_UNITS*OPER_W-1:0]   fu_oper,
  output logic [NUM_UNITS*RMASK_W-1:0]  fu_rdmask_n,
  input  logic [NUM_UNITS-1:0]          fu_busy,
  input  logic [NUM_UNITS-1:0]          fu_exc,
  output logic                          core_busy,
  output logic                          terminate,
  output logic                          exc_any
);
  logic                 dispatch_now;
  logic                 halt_now;
  logic                 nop_now;
  logic                 nop_active;
  logic                 unit_busy_any;
  logic [NUM_UNITS-1:0] class_hit;
  logic [NUM_UNITS-1:0] lane_sel;

  assign dispatch_now = in_valid & kind_is_exec(in_kind);
  assign halt_now     = in_valid & kind_is_halt(in_kind);
  assign nop_now      = in_valid & kind_is_nop(in_kind);

  unit_match #(
    .NUM_UNITS (NUM_UNITS),
    .CLASS_W   (CLASS_W),
    .UNIT_MASKS(UNIT_MASKS)
  ) u_match (
    .cls(in_class),
    .hit(class_hit)
  );

  assign lane_sel = dispatch_now ? class_hit : '0;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_lane
    lane_drive #(
      .OPER_W (OPER_W),
      .RMASK_W(RMASK_W)
    ) u_lane (
      .sel         (lane_sel[u]),
      .unit_busy   (fu_busy[u]),
      .oper_in     (in_oper),
      .rdmask_in   (in_rdmask),
      .issue       (fu_issue[u]),
      .oper_out    (fu_oper[u*OPER_W +: OPER_W]),
      .rdmask_n_out(fu_rdmask_n[u*RMASK_W +: RMASK_W])
    );
  end

  nop_hold #(.NOP_HOLD(NOP_HOLD)) u_nop (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (nop_now),
    .active(nop_active)
  );

  assign unit_busy_any = |fu_busy;
  assign core_busy     = nop_active | nop_now | unit_busy_any;
  assign in_ready      = ~core_busy;
  assign exc_any       = |fu_exc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      terminate <= 1'b0;
    end else if (halt_now) begin
      terminate <= 1'b1;
    end
  end

  AST_ISSUE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fu_issue)); // R1
  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (fu_issue == '0)); // R3
  AST_HALT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_now |-> (fu_issue == '0)); // R4
  AST_HALT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_now |=> terminate); // R4
  AST_TERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    terminate |=> terminate); // R5
  AST_NOP_BUSY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    nop_now |=> core_busy); // R6
  AST_UNIT_BUSY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_busy != '0) |-> !in_ready); // R7
endmodule

// File: tb/sim_fu_dispatch.sv
module sim_fu_dispatch;
  localparam int N = 4;
  localparam int CW = 4;
  localparam int OW = 16;
  localparam int MW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_kind = 2'd0;
  logic [CW-1:0] in_class = '0;
  logic [OW-1:0] in_oper = '0;
  logic [MW-1:0] in_rdmask = '0;
  logic [N-1:0] fu_issue;
  logic [N*OW-1:0] fu_oper;
  logic [N*MW-1:0] fu_rdmask_n;
  logic [N-1:0] fu_busy = '0;
  logic [N-1:0] fu_exc = '0;
  logic core_busy, terminate, exc_any;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fu_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_class(in_class), .in_oper(in_oper),
    .in_rdmask(in_rdmask), .fu_issue(fu_issue), .fu_oper(fu_oper),
    .fu_rdmask_n(fu_rdmask_n), .fu_busy(fu_busy), .fu_exc(fu_exc),
    .core_busy(core_busy), .terminate(terminate), .exc_any(exc_any)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // bench-side model of class masks: unit u owns class bit u
  function automatic logic [N-1:0] exp_hits(input logic [CW-1:0] c);
    logic [N-1:0] r;
    for (int u = 0; u < N; u++) r[u] = c[u];
    return r;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; fu_busy = '0;
    step(); step();
    rst_n = 1'b1;
    step(); #1;
    chk("R10 terminate", terminate, 0);
    chk("R10 busy", core_busy, 0);
    chk("R10 ready", in_ready, 1);
    chk("R10 issue", fu_issue, 0);
  endtask

  task automatic t_classes();
    for (int c = 0; c <= N; c++) begin
      logic [CW-1:0] cls;
      logic [N-1:0] e;
      cls = (c == N) ? '0 : CW'(1 << c);
      e = exp_hits(cls);
      in_valid = 1'b1; in_kind = (c % 2 == 0) ? 2'd0 : 2'd3;
      in_class = cls; in_oper = OW'(16'h1230 + c); in_rdmask = 4'b0110;
      #1;
      chk("R1 issue", fu_issue, e);
      for (int u = 0; u < N; u++) begin
        chk("R2 oper lane", fu_oper[u*OW +: OW], e[u] ? in_oper : '0);
        chk("R8 rdmask lane", fu_rdmask_n[u*MW +: MW], e[u] ? 4'b1001 : 4'b0000);
      end
      step();
    end
    in_valid = 1'b0;
  endtask

  task automatic t_no_valid();
    in_valid = 1'b0; in_kind = 2'd0; in_class = 4'b0100;
    #1;
    chk("R3 no issue", fu_issue, 0);
    chk("R2 oper zero", fu_oper, 0);
    step();
  endtask

  task automatic t_busy();
    in_valid = 1'b1; in_kind = 2'd0; in_class = 4'b0010; in_rdmask = 4'b0101;
    fu_busy = 4'b0010;
    #1;
    chk("R7 busy", core_busy, 1);
    chk("R7 ready", in_ready, 0);
    step();
    in_valid = 1'b0;
    #1;
    chk("R8 held lane", fu_rdmask_n[1*MW +: MW], 4'b1010);
    chk("R8 other lane", fu_rdmask_n[0 +: MW], 0);
    chk("R7 busy held", core_busy, 1);
    step();
    fu_busy = '0;
    #1;
    chk("R7 idle", in_ready, 1);
    chk("R8 released", fu_rdmask_n, 0);
    step();
  endtask

  task automatic t_nop();
    in_valid = 1'b1; in_kind = 2'd2; in_class = 4'b0001;
    #1;
    chk("R6 same cycle", core_busy, 1);
    chk("R6 no issue", fu_issue, 0);
    step();
    in_valid = 1'b0;
    #1; chk("R6 hold1", core_busy, 1);
    step(); #1; chk("R6 hold2", core_busy, 1);
    step(); #1; chk("R6 end", core_busy, 0);
    chk("R7 ready after nop", in_ready, 1);
    step();
  endtask

  task automatic t_exc();
    fu_exc = 4'b0000; #1; chk("R9 none", exc_any, 0);
    fu_exc = 4'b1000; #1; chk("R9 one", exc_any, 1);
    fu_exc = 4'b0101; #1; chk("R9 two", exc_any, 1);
    fu_exc = '0;
    step();
  endtask

  task automatic t_halt();
    #1; chk("R5 pre", terminate, 0);
    in_valid = 1'b1; in_kind = 2'd1; in_class = 4'b0100;
    #1;
    chk("R4 no issue", fu_issue, 0);
    chk("R4 not yet", terminate, 0);
    step();
    in_valid = 1'b0;
    #1; chk("R4 set", terminate, 1);
    step(); step(); #1;
    chk("R5 sticky", terminate, 1);
    t_reset();
    chk("R5 cleared", terminate, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog got=hang exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_classes();
    t_no_valid();
    t_busy();
    t_nop();
    t_exc();
    t_halt();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule